// File: doc/BRIEF.md
# Windowed Register File

This block holds the integer registers of a core that passes procedure arguments through overlapping register windows. Software sees 32 registers at any time. Eight are shared globals. The other 24 form a window of three groups: outgoing arguments, private locals and incoming arguments. A save command opens a new window for a callee, and a restore command returns to the caller. Neither command needs software to save or restore registers.

Incoming-argument groups from earlier windows are kept on a small circular stack of frames on chip. A save that finds every on-chip frame occupied first streams the oldest frame out to an external memory agent, eight words, through a valid/ready handshake. A restore that finds no frame on chip first receives a frame back from that agent. The agent must return frames last-in, first-out. While either transfer runs, `busy` is high and the block ignores all commands and writes, so the pipeline must hold them.

Top module: `windowed_regfile`

## Requirements
- R1: Register numbers map to groups as follows: 0-7 global, 8-15 outgoing, 16-23 local, 24-31 incoming. Reads are combinational. A write lands at the next clock edge.
- R2: Global registers keep their values across every save and restore.
- R3: A save pushes the incoming group onto the frame stack, moves the outgoing group into the incoming group, and clears both the local and the outgoing groups to zero.
- R4: A restore moves the incoming group into the outgoing group, clears the local group, and loads the incoming group from the most recently pushed frame.
- R5: A save issued while all FRAMES on-chip frames are occupied first streams the oldest frame out. It sends 8 words, word k being that frame's register 24+k. Each word is held stable while `spill_valid` is high and `spill_ready` is low. The save completes on the eighth accepted word.
- R6: A restore issued with no frame on chip raises `fill_ready` and accepts 8 words, word k going to register 24+k. The restore completes on the eighth accepted word.
- R7: `busy` is high exactly while a spill or fill runs. A save, restore or write presented while `busy` is high has no effect.
- R8: A write issued in the same cycle as an accepted save or restore takes effect before the window moves.
- R9: When save and restore are requested in the same cycle, only the save is performed.
- R10: Reset clears all 32 registers and leaves the frame stack empty, so the first restore after reset performs a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Open a new window |
| restore_req | input | 1 | Return to the previous window |
| busy | output | 1 | Spill or fill in progress |
| spill_valid | output | 1 | Spill word available |
| spill_ready | input | 1 | Memory agent accepts spill word |
| spill_data | output | XLEN | Spill word |
| fill_valid | input | 1 | Fill word available |
| fill_ready | output | 1 | Block accepts fill word |
| fill_data | input | XLEN | Fill word |

## Verification
The bench builds the block with FRAMES=4 and XLEN=16. With only four on-chip frames, a call chain of seven or eight levels is enough to force spills on the way down and fills on the way back up. The bench therefore walks the full depth twice, each time with a different data pattern. It reads all 32 registers after every command and compares each spilled frame with an arithmetic model of the whole window stack. Throttled handshakes and stray commands issued during transfers cover the stall and ignore rules.

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int XLEN   = 32,
  parameter int FRAMES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  output logic            busy,
  output logic            spill_valid,
  input  logic            spill_ready,
  output logic [XLEN-1:0] spill_data,
  input  logic            fill_valid,
  output logic            fill_ready,
  input  logic [XLEN-1:0] fill_data
);
  localparam int GW   = 8;
  localparam int OUTB = 8;
  localparam int LOCB = 16;
  localparam int INB  = 24;
  localparam int PW   = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int CW   = $clog2(FRAMES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SPILL, ST_FILL} st_t;

  st_t                st;
  logic [XLEN-1:0]    rf  [32];
  logic [XLEN-1:0]    wv  [32];
  logic [XLEN-1:0]    stk [FRAMES][GW];
  logic [XLEN-1:0]    popw [GW];
  logic [PW-1:0]      base, push_slot, pop_slot;
  logic [CW-1:0]      cnt;
  logic [2:0]         beat;
  logic idle, full, empty, acc_save, acc_rest, last_spill, last_fill, do_save, do_rest, wr_go;

  assign idle       = (st == ST_IDLE);
  assign full       = (cnt == CW'(FRAMES));
  assign empty      = (cnt == '0);
  assign acc_save   = idle && save_req;
  assign acc_rest   = idle && restore_req && !save_req;
  assign last_spill = (st == ST_SPILL) && spill_ready && (beat == 3'd7);
  assign last_fill  = (st == ST_FILL) && fill_valid && (beat == 3'd7);
  assign do_save    = (acc_save && !full) || last_spill;
  assign do_rest    = (acc_rest && !empty) || last_fill;
  assign wr_go      = wr_en && idle;
  assign push_slot  = base + cnt[PW-1:0];
  assign pop_slot   = base + cnt[PW-1:0] - PW'(1);

  assign rd_a_data   = rf[rd_a_idx];
  assign rd_b_data   = rf[rd_b_idx];
  assign busy        = !idle;
  assign spill_valid = (st == ST_SPILL);
  assign spill_data  = stk[base][beat];
  assign fill_ready  = (st == ST_FILL);

  always_comb begin
    for (int i = 0; i < 32; i++) wv[i] = rf[i];
    if (wr_go) wv[wr_idx] = wr_data;
  end

  always_comb begin
    for (int k = 0; k < GW; k++) popw[k] = stk[pop_slot][k];
    if (st == ST_FILL) popw[GW-1] = fill_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      for (int i = 0; i < 32; i++) rf[i] <= wv[i];
      if (do_save) begin
        for (int k = 0; k < GW; k++) begin
          rf[INB+k]  <= wv[OUTB+k];
          rf[OUTB+k] <= '0;
          rf[LOCB+k] <= '0;
        end
      end else if (do_rest) begin
        for (int k = 0; k < GW; k++) begin
          rf[OUTB+k] <= wv[INB+k];
          rf[LOCB+k] <= '0;
          rf[INB+k]  <= popw[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_save)
      for (int k = 0; k < GW; k++) stk[push_slot][k] <= wv[INB+k];
    if ((st == ST_FILL) && fill_valid)
      stk[pop_slot][beat] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      base <= '0;
      cnt  <= '0;
      beat <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          beat <= '0;
          if (acc_save) begin
            if (full) st <= ST_SPILL;
            else      cnt <= cnt + CW'(1);
          end else if (acc_rest) begin
            if (empty) st <= ST_FILL;
            else       cnt <= cnt - CW'(1);
          end
        end
        ST_SPILL: if (spill_ready) begin
          beat <= beat + 3'd1;
          if (beat == 3'd7) begin
            st   <= ST_IDLE;
            base <= base + PW'(1);
          end
        end
        ST_FILL: if (fill_valid) begin
          beat <= beat + 3'd1;
          if (beat == 3'd7) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/windowed_regfile_checker.sv
module windowed_regfile_checker #(
  parameter int XLEN   = 32,
  parameter int FRAMES = 8,
  parameter int CW     = $clog2(FRAMES + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            save_req,
  input logic            restore_req,
  input logic            busy,
  input logic            spill_valid,
  input logic            spill_ready,
  input logic [XLEN-1:0] spill_data,
  input logic            fill_valid,
  input logic            fill_ready,
  input logic [CW-1:0]   cnt
);
  a_r3_save_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && save_req && cnt < CW'(FRAMES)) |=> (cnt == $past(cnt) + CW'(1)));

  a_r4_restore_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && restore_req && !save_req && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  a_r5_full_save_spills: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && save_req && cnt == CW'(FRAMES)) |=> spill_valid);

  a_r5_spill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_valid && !spill_ready) |=> (spill_valid && $stable(spill_data)));

  a_r6_empty_restore_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && restore_req && !save_req && cnt == '0) |=> fill_ready);

  a_r6_fill_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ready && !fill_valid) |=> fill_ready);

  a_r7_busy_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cnt));

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAMES));
endmodule

bind windowed_regfile windowed_regfile_checker #(.XLEN(XLEN), .FRAMES(FRAMES)) chk_i (
  .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
  .busy(busy), .spill_valid(spill_valid), .spill_ready(spill_ready),
  .spill_data(spill_data), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .cnt(cnt)
);

// File: tb/windowed_regfile_tb_top.sv
module windowed_regfile_tb_top;
  localparam int XW = 16;
  localparam int NF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] rd_a_idx, rd_b_idx, wr_idx;
  logic [XW-1:0] rd_a_data, rd_b_data, wr_data, spill_data, fill_data;
  logic wr_en, save_req, restore_req, busy, spill_valid, spill_ready, fill_valid, fill_ready;

  always #2 clk = ~clk;

  windowed_regfile #(.XLEN(XW), .FRAMES(NF)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req), .busy(busy),
    .spill_valid(spill_valid), .spill_ready(spill_ready), .spill_data(spill_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
  );

  int nchk = 0;
  int nbad = 0;
  logic [XW-1:0] m_rf [32];
  logic [XW-1:0] m_frames [64][8];
  logic [XW-1:0] mem_frames [64][8];
  int m_depth = 0, m_onchip = 0, mem_depth = 0;

  function automatic logic [XW-1:0] vmk(int a, int b, int c);
    return XW'(a * 1000 + b * 37 + c * 3 + 5);
  endfunction

  task automatic chk(string tag, logic [XW-1:0] got, logic [XW-1:0] exp, string what);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 32; i += 2) begin
      rd_a_idx = 5'(i);
      rd_b_idx = 5'(i + 1);
      #1;
      chk((i < 8) ? "R2" : tag, rd_a_data, m_rf[i], $sformatf("reg %0d", i));
      chk((i < 8) ? "R2" : tag, rd_b_data, m_rf[i+1], $sformatf("reg %0d", i + 1));
    end
  endtask

  task automatic model_apply(logic sv, logic rs, logic we, logic [4:0] wi, logic [XW-1:0] wd);
    logic [XW-1:0] f [8];
    if (we) m_rf[wi] = wd;
    if (sv) begin
      for (int k = 0; k < 8; k++) m_frames[m_depth][k] = m_rf[24+k];
      m_depth++;
      for (int k = 0; k < 8; k++) begin
        m_rf[24+k] = m_rf[8+k];
        m_rf[8+k]  = '0;
        m_rf[16+k] = '0;
      end
      if (m_onchip < NF) m_onchip++;
    end else if (rs) begin
      if (m_depth > 0) begin
        m_depth--;
        for (int k = 0; k < 8; k++) f[k] = m_frames[m_depth][k];
      end else begin
        for (int k = 0; k < 8; k++) f[k] = '0;
      end
      for (int k = 0; k < 8; k++) begin
        m_rf[8+k]  = m_rf[24+k];
        m_rf[16+k] = '0;
        m_rf[24+k] = f[k];
      end
      if (m_onchip > 0) m_onchip--;
    end
  endtask

  task automatic op(logic sv, logic rs, logic we, logic [4:0] wi, logic [XW-1:0] wd, string tag);
    logic exp_sp, exp_fl;
    logic [XW-1:0] old_fr [8];
    logic [XW-1:0] sbuf [8];
    logic [XW-1:0] fbuf [8];
    int sb, fb, g;
    exp_sp = sv && (m_onchip == NF);
    exp_fl = !sv && rs && (m_onchip == 0);
    for (int k = 0; k < 8; k++) begin
      old_fr[k] = exp_sp ? m_frames[m_depth-NF][k] : '0;
      sbuf[k] = '0;
      fbuf[k] = '0;
    end
    if (exp_fl && mem_depth > 0) begin
      mem_depth--;
      for (int k = 0; k < 8; k++) fbuf[k] = mem_frames[mem_depth][k];
    end
    @(negedge clk);
    save_req = sv; restore_req = rs; wr_en = we; wr_idx = wi; wr_data = wd;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0; wr_en = 1'b0;
    chk("R7", {15'd0, busy}, {15'd0, exp_sp || exp_fl}, "busy after command");
    sb = 0; fb = 0; g = 0;
    while (busy && g < 200) begin
      spill_ready = (g % 3) != 1;
      fill_valid  = (g % 3) != 1;
      fill_data   = fbuf[fb & 7];
      save_req = 1'b1; restore_req = 1'b1; wr_en = 1'b1;
      wr_idx = 5'(g % 32); wr_data = 16'hdead;
      #1;
      if (spill_valid && spill_ready) begin
        if (sb < 8) sbuf[sb] = spill_data;
        sb++;
      end
      if (fill_valid && fill_ready) fb++;
      @(negedge clk);
      g++;
    end
    save_req = 1'b0; restore_req = 1'b0; wr_en = 1'b0;
    spill_ready = 1'b0; fill_valid = 1'b0;
    if (exp_sp) begin
      chk("R5", XW'(sb), XW'(8), "spill beats");
      for (int k = 0; k < 8; k++) begin
        chk("R5", sbuf[k], old_fr[k], $sformatf("spill word %0d", k));
        mem_frames[mem_depth][k] = sbuf[k];
      end
      mem_depth++;
    end
    if (exp_fl) chk("R6", XW'(fb), XW'(8), "fill beats");
    model_apply(sv, rs, we, wi, wd);
    check_all(tag);
  endtask

  initial begin
    #(200000 * 4);
    nchk++;
    nbad++;
    $display("FAIL R7 watchdog expired got hang exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rd_a_idx = '0; rd_b_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    save_req = 1'b0; restore_req = 1'b0; spill_ready = 1'b0; fill_valid = 1'b0; fill_data = '0;
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {15'd0, busy}, 16'd0, "busy after reset");
    check_all("R10");
    op(1'b0, 1'b1, 1'b0, 5'd0, '0, "R10");

    for (int i = 0; i < 32; i++) op(1'b0, 1'b0, 1'b1, 5'(i), vmk(9, 0, i), "R1");

    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < NF + 4; d++) begin
        for (int i = 8; i < 24; i++) op(1'b0, 1'b0, 1'b1, 5'(i), vmk(p, d, i), "R1");
        if (d % 2 == 0) op(1'b1, 1'b0, 1'b0, 5'd0, '0, "R3");
        else            op(1'b1, 1'b0, 1'b1, 5'(8 + d % 8), vmk(p + 5, d, 1), "R8");
      end
      for (int d = 0; d < NF + 4; d++) begin
        op(1'b0, 1'b0, 1'b1, 5'(16 + d % 8), vmk(p + 7, d, 2), "R1");
        if (d % 2 == 0) op(1'b0, 1'b1, 1'b0, 5'd0, '0, "R4");
        else            op(1'b0, 1'b1, 1'b1, 5'(24 + d % 8), vmk(p + 3, d, 4), "R8");
      end
    end

    for (int i = 8; i < 16; i++) op(1'b0, 1'b0, 1'b1, 5'(i), vmk(4, 4, i), "R1");
    op(1'b1, 1'b1, 1'b0, 5'd0, '0, "R9");
    op(1'b1, 1'b1, 1'b1, 5'd3, 16'h1234, "R9");
    op(1'b0, 1'b1, 1'b0, 5'd0, '0, "R4");
    op(1'b0, 1'b1, 1'b0, 5'd0, '0, "R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule